// File: doc/BRIEF.md
# Multi-Source XOR Descriptor Executor

This block accepts one fully decoded 128-byte descriptor, carries out the operation that descriptor asks for, and reports completion. Three operations are supported. A no-operation moves no data and only completes. A copy streams one source buffer into a destination buffer. A parity operation combines between one and eight source buffers with XOR into a single destination buffer, which is how single-parity (RAID5) stripes are built. Memory is reached through a plain word-wide port. Each request is a read or a write of one 32-bit word, and read data returns exactly one cycle after the request.

The descriptor arrives as 32 little-endian words on a flat bus. Word 0 bits [15:0] carry an identifier. Word 2 is the control word and word 3 is the byte count. Words 4 to 7 hold the copy source and the destination, and words 8 to 19 hold the packed source-address table. For every destination word, the engine reads the same-offset word from each active source in turn, folds it into one accumulator, and writes the result once the last source has been read. After all words are done, or at once for a no-op or a rejected descriptor, a one-cycle completion pulse carries the identifier, an interrupt flag and an error flag.

Top module: `xor_desc_exec`

## Requirements
- R1: After reset `desc_ready` is 1, `done` is 0 and no memory request is made. A descriptor is taken only while `desc_ready` is high, and `desc_valid` has no effect while an operation is running.
- R2: Mode 0 (control bits [31:28] = 0) is a no-op: it makes no memory access and completes with `done_err` = 0, whatever the byte count.
- R3: Mode 1 is a copy. The source address is {word 5 [15:0], word 4}, the destination address is {word 7 [15:0], word 6}, and destination word i receives source word i, for byte_count/4 words.
- R4: Mode 6 is XOR. The active source count is read from control bits [25:22], and destination word i becomes the XOR of word i of sources 0 through count-1.
- R5: Source s lives in table pair k = s/2. Its low 32 address bits are table word 3k when s is even, or word 3k+1 when s is odd. Its upper 16 bits are bits [15:0] of table word 3k+2 when s is even, or bits [31:16] when s is odd. The table starts at descriptor word 8.
- R6: Each destination word is written exactly once, and only after every active source word at that offset has been read. A copy or XOR performs count×(byte_count/4) reads and byte_count/4 writes.
- R7: The descriptor completes with `done_err` = 1 and makes no memory access in any of these cases: a mode other than 0, 1 or 6; an XOR whose source count is 0 or above 8; an XOR with control bit 17 (parity output enable) clear; or a copy or XOR whose byte count is not a multiple of 4.
- R8: `done_id` shows descriptor word 0 bits [15:0] of the descriptor being completed, unchanged, even if other descriptors are presented while it runs.
- R9: `done_irq` equals control bit 27 during the completion pulse, for good and rejected descriptors alike, and is 0 at all other times.
- R10: `done` is high for exactly one cycle per descriptor, and `desc_ready` returns in the following cycle.
- R11: A copy or XOR with a byte count of 0 completes without error and makes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid | input | 1 | Descriptor on `desc_data` is offered |
| desc_ready | output | 1 | Engine idle; an offered descriptor is taken this cycle |
| desc_data | input | 1024 | Descriptor, word n at bits [32n+31:32n] |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 48 | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| done | output | 1 | One-cycle completion pulse |
| done_id | output | 16 | Identifier of the completed descriptor |
| done_irq | output | 1 | Interrupt request with the completion |
| done_err | output | 1 | Descriptor was rejected |

## Verification
The assertions take for granted that the memory never stalls and always returns read data in the cycle after the request. The ordering property, which requires every write to follow a read two cycles earlier, depends on that fixed latency. The bench memory model registers its read data on the request edge with no wait states, so it stays inside this assumption. Descriptors are held on `desc_data` only in the accepting cycle. While an operation runs, the bench deliberately drives a conflicting descriptor with `desc_valid` high and then confirms that it left no trace.

// File: rtl/xde_pkg.sv
package xde_pkg;
    // descriptor word positions the block decodes
    localparam int CTRL_WORD   = 2;
    localparam int BCNT_WORD   = 3;
    localparam int PAT_WORD    = 4;
    localparam int TBL_WORD    = 8;
    localparam int ADDR_LO_W   = 32;
    localparam int ADDR_HI_W   = 16;
    localparam int ADDR_W      = ADDR_LO_W + ADDR_HI_W;

    localparam logic [3:0] OP_NOP  = 4'd0;
    localparam logic [3:0] OP_COPY = 4'd1;
    localparam logic [3:0] OP_XOR  = 4'd6;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RD   = 3'd1,
        ST_ACC  = 3'd2,
        ST_WR   = 3'd3,
        ST_DONE = 3'd4
    } xde_state_e;
endpackage

// File: rtl/xde_decode.sv
module xde_decode
    import xde_pkg::*;
#(
    parameter  int MAX_SRC    = 8,
    parameter  int WORD_BYTES = 4,
    localparam int SRC_W      = $clog2(MAX_SRC + 1),
    localparam int ALIGN_W    = $clog2(WORD_BYTES),
    localparam int WCNT_W     = 32 - ALIGN_W
) (
    input  logic [31:0]       ctrl_word,
    input  logic [31:0]       byte_cnt,
    output logic [SRC_W-1:0]  nsrc,
    output logic [WCNT_W-1:0] nwords,
    output logic              irq_req,
    output logic              is_copy,
    output logic              bad,
    output logic              moves
);
    logic [3:0] mode;
    logic [3:0] cnt_field;
    logic       par_en;
    logic       misaligned;
    logic       ctrl_unused;

    assign mode        = ctrl_word[31:28];
    assign irq_req     = ctrl_word[27];
    assign cnt_field   = ctrl_word[25:22];
    assign par_en      = ctrl_word[17];
    assign ctrl_unused = ^{ctrl_word[26], ctrl_word[21:18], ctrl_word[16:0]};
    assign misaligned  = |byte_cnt[ALIGN_W-1:0];
    assign nwords      = byte_cnt[31:ALIGN_W];

    always_comb begin
        nsrc    = '0;
        is_copy = 1'b0;
        bad     = 1'b0;
        unique case (mode)
            OP_NOP: begin
                bad = 1'b0;
            end
            OP_COPY: begin
                is_copy = 1'b1;
                nsrc    = SRC_W'(1);
                bad     = misaligned;
            end
            OP_XOR: begin
                nsrc = SRC_W'(cnt_field);
                bad  = misaligned || (cnt_field == 4'd0) ||
                       (int'(cnt_field) > MAX_SRC) || !par_en;
            end
            default: begin
                bad = 1'b1;
            end
        endcase
    end

    assign moves = !bad && (mode != OP_NOP) && (nwords != '0);
endmodule

// File: rtl/xde_addr_unpack.sv
module xde_addr_unpack
    import xde_pkg::*;
#(
    parameter  int MAX_SRC  = 8,
    localparam int NPAIR    = (MAX_SRC + 1) / 2,
    localparam int TBL_BITS = 32 * 3 * NPAIR
) (
    input  logic [TBL_BITS-1:0]              tbl,
    output logic [MAX_SRC-1:0][ADDR_W-1:0]   src_addr
);
    for (genvar s = 0; s < MAX_SRC; s++) begin : g_src
        localparam int PAIR = s / 2;
        localparam int ODD  = s % 2;
        // low half from its own word, high half from the shared third word
        assign src_addr[s] = {tbl[(3*PAIR+2)*32 + ODD*ADDR_HI_W +: ADDR_HI_W],
                              tbl[(3*PAIR+ODD)*32 +: ADDR_LO_W]};
    end
endmodule

// File: rtl/xor_desc_exec.sv
module xor_desc_exec
    import xde_pkg::*;
#(
    parameter  int MAX_SRC    = 8,
    parameter  int DESC_WORDS = 32,
    parameter  int DATA_W     = 32,
    parameter  int ID_W       = 16,
    localparam int WORD_BYTES = DATA_W / 8,
    localparam int DESC_W     = DESC_WORDS * 32,
    localparam int SRC_W      = $clog2(MAX_SRC + 1),
    localparam int SEL_W      = $clog2(MAX_SRC),
    localparam int ALIGN_W    = $clog2(WORD_BYTES),
    localparam int WCNT_W     = 32 - ALIGN_W,
    localparam int TBL_WORDS  = 3 * ((MAX_SRC + 1) / 2),
    localparam int TBL_END    = (TBL_WORD + TBL_WORDS) * 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_valid,
    output logic              desc_ready,
    input  logic [DESC_W-1:0] desc_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic [ID_W-1:0]   done_id,
    output logic              done_irq,
    output logic              done_err
);
    typedef struct packed {
        xde_state_e                     st;
        logic [MAX_SRC-1:0][ADDR_W-1:0] src;
        logic [ADDR_W-1:0]              dst;
        logic [SRC_W-1:0]               nsrc;
        logic [SRC_W-1:0]               sidx;
        logic [WCNT_W-1:0]              nwords;
        logic [WCNT_W-1:0]              widx;
        logic [DATA_W-1:0]              acc;
        logic [ID_W-1:0]                id;
        logic                           iod;
        logic                           err;
    } exec_state_t;

    exec_state_t st_d, st_q;

    // decoded descriptor fields
    logic [SRC_W-1:0]               dec_nsrc;
    logic [WCNT_W-1:0]              dec_nwords;
    logic                           dec_irq;
    logic                           dec_copy;
    logic                           dec_bad;
    logic                           dec_moves;
    logic [MAX_SRC-1:0][ADDR_W-1:0] tbl_addr;
    logic [MAX_SRC-1:0][ADDR_W-1:0] src_load;
    logic [ADDR_W-1:0]              copy_addr;
    logic [ADDR_W-1:0]              dst_addr;
    logic [ADDR_W-1:0]              word_off;
    logic [SEL_W-1:0]               sel;
    logic                           desc_unused;

    xde_decode #(
        .MAX_SRC    (MAX_SRC),
        .WORD_BYTES (WORD_BYTES)
    ) decode_i (
        .ctrl_word (desc_data[CTRL_WORD*32 +: 32]),
        .byte_cnt  (desc_data[BCNT_WORD*32 +: 32]),
        .nsrc      (dec_nsrc),
        .nwords    (dec_nwords),
        .irq_req   (dec_irq),
        .is_copy   (dec_copy),
        .bad       (dec_bad),
        .moves     (dec_moves)
    );

    xde_addr_unpack #(
        .MAX_SRC (MAX_SRC)
    ) unpack_i (
        .tbl      (desc_data[TBL_END-1:TBL_WORD*32]),
        .src_addr (tbl_addr)
    );

    assign copy_addr = {desc_data[(PAT_WORD+1)*32 +: ADDR_HI_W],
                        desc_data[PAT_WORD*32 +: ADDR_LO_W]};
    assign dst_addr  = {desc_data[(PAT_WORD+3)*32 +: ADDR_HI_W],
                        desc_data[(PAT_WORD+2)*32 +: ADDR_LO_W]};

    assign desc_unused = ^{desc_data[31:ID_W], desc_data[63:32],
                           desc_data[(PAT_WORD+1)*32+ADDR_HI_W +: 32-ADDR_HI_W],
                           desc_data[(PAT_WORD+3)*32+ADDR_HI_W +: 32-ADDR_HI_W],
                           desc_data[DESC_W-1:TBL_END]};

    always_comb begin
        src_load = tbl_addr;
        if (dec_copy) begin
            src_load[0] = copy_addr;
        end
    end

    assign sel      = st_q.sidx[SEL_W-1:0];
    assign word_off = {{(ADDR_W-WCNT_W-ALIGN_W){1'b0}}, st_q.widx, {ALIGN_W{1'b0}}};

    always_comb begin
        st_d      = st_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (st_q.st)
            ST_IDLE: begin
                if (desc_valid) begin
                    st_d.id     = desc_data[ID_W-1:0];
                    st_d.iod    = dec_irq;
                    st_d.err    = dec_bad;
                    st_d.nsrc   = dec_nsrc;
                    st_d.nwords = dec_nwords;
                    st_d.src    = src_load;
                    st_d.dst    = dst_addr;
                    st_d.sidx   = '0;
                    st_d.widx   = '0;
                    st_d.acc    = '0;
                    st_d.st     = dec_moves ? ST_RD : ST_DONE;
                end
            end
            ST_RD: begin
                mem_req  = 1'b1;
                mem_addr = st_q.src[sel] + word_off;
                st_d.st  = ST_ACC;
            end
            ST_ACC: begin
                st_d.acc = st_q.acc ^ mem_rdata;
                if (st_q.sidx == st_q.nsrc - SRC_W'(1)) begin
                    st_d.st = ST_WR;
                end else begin
                    st_d.sidx = st_q.sidx + SRC_W'(1);
                    st_d.st   = ST_RD;
                end
            end
            ST_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = st_q.dst + word_off;
                mem_wdata = st_q.acc;
                st_d.acc  = '0;
                st_d.sidx = '0;
                if (st_q.widx == st_q.nwords - WCNT_W'(1)) begin
                    st_d.st = ST_DONE;
                end else begin
                    st_d.widx = st_q.widx + WCNT_W'(1);
                    st_d.st   = ST_RD;
                end
            end
            ST_DONE: begin
                st_d.st = ST_IDLE;
            end
            default: begin
                st_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign desc_ready = (st_q.st == ST_IDLE);
    assign done       = (st_q.st == ST_DONE);
    assign done_id    = st_q.id;
    assign done_irq   = done && st_q.iod;
    assign done_err   = done && st_q.err;
endmodule

// File: rtl/xde_exec_chk.sv
module xde_exec_chk (
    input logic clk,
    input logic rst_n,
    input logic desc_valid,
    input logic desc_ready,
    input logic mem_req,
    input logic mem_we,
    input logic done,
    input logic done_irq,
    input logic done_err
);
    // R1: idle engine never touches memory
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        desc_ready |-> !mem_req);

    // R1: an accepted descriptor makes the engine busy next cycle
    p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && desc_ready) |=> !desc_ready);

    // R6: a write is always preceded by a read two cycles before
    p_wr_after_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> $past(mem_req && !mem_we, 2));

    // R10: completion lasts one cycle and the engine is then ready
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && desc_ready));

    // R10: no memory access during completion
    p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    // R9: interrupt and error flags only appear with completion
    p_flags_in_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_irq || done_err) |-> done);
endmodule

bind xor_desc_exec xde_exec_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .desc_valid (desc_valid),
    .desc_ready (desc_ready),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .done       (done),
    .done_irq   (done_irq),
    .done_err   (done_err)
);

// File: tb/xor_desc_exec_tb_top.sv
`timescale 1ns/1ps
module xor_desc_exec_tb_top;
    typedef struct packed {
        logic [3:0] mode;
        logic [3:0] cnt;
        logic       pen;
        logic       iod;
        logic [7:0] bcnt;
        logic       err;
    } vec_t;

    localparam int NVEC = 19;
    localparam vec_t VECS [NVEC] = '{
        '{4'd6,  4'd1, 1'b1, 1'b0, 8'd16, 1'b0},
        '{4'd6,  4'd2, 1'b1, 1'b1, 8'd16, 1'b0},
        '{4'd6,  4'd3, 1'b1, 1'b0, 8'd12, 1'b0},
        '{4'd6,  4'd4, 1'b1, 1'b0, 8'd16, 1'b0},
        '{4'd6,  4'd5, 1'b1, 1'b0, 8'd8,  1'b0},
        '{4'd6,  4'd6, 1'b1, 1'b0, 8'd16, 1'b0},
        '{4'd6,  4'd7, 1'b1, 1'b1, 8'd16, 1'b0},
        '{4'd6,  4'd8, 1'b1, 1'b0, 8'd20, 1'b0},
        '{4'd1,  4'd0, 1'b0, 1'b1, 8'd20, 1'b0},
        '{4'd0,  4'd0, 1'b0, 1'b1, 8'd16, 1'b0},
        '{4'd0,  4'd0, 1'b0, 1'b0, 8'd0,  1'b0},
        '{4'd2,  4'd2, 1'b1, 1'b1, 8'd16, 1'b1},
        '{4'd7,  4'd2, 1'b1, 1'b0, 8'd16, 1'b1},
        '{4'd6,  4'd0, 1'b1, 1'b0, 8'd16, 1'b1},
        '{4'd6,  4'd9, 1'b1, 1'b1, 8'd16, 1'b1},
        '{4'd6,  4'd3, 1'b0, 1'b0, 8'd16, 1'b1},
        '{4'd6,  4'd2, 1'b1, 1'b0, 8'd6,  1'b1},
        '{4'd1,  4'd0, 1'b0, 1'b0, 8'd0,  1'b0},
        '{4'd15, 4'd1, 1'b1, 1'b1, 8'd16, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          desc_valid = 1'b0;
    logic          desc_ready;
    logic [1023:0] desc_data = '0;
    logic          mem_req;
    logic          mem_we;
    logic [47:0]   mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic          done;
    logic [15:0]   done_id;
    logic          done_irq;
    logic          done_err;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int stray  = 0;
    logic init_req = 1'b0;
    logic [31:0] mem [0:2047];

    always #2 clk = ~clk;

    xor_desc_exec dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .desc_valid (desc_valid),
        .desc_ready (desc_ready),
        .desc_data  (desc_data),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .done       (done),
        .done_id    (done_id),
        .done_irq   (done_irq),
        .done_err   (done_err)
    );

    function automatic logic [31:0] pat(int bank, int off);
        return (32'h9E3779B9 * (bank * 256 + off + 1)) ^ 32'h5A5A0000;
    endfunction

    // memory model: bank = addr[34:32], word = addr[9:2], one-cycle read
    always @(posedge clk) begin
        if (init_req) begin
            for (int k = 0; k < 2048; k++) mem[k] <= pat(k / 256, k % 256);
            rd_cnt <= 0;
            wr_cnt <= 0;
            stray  <= 0;
        end else if (mem_req) begin
            if (mem_addr[47:35] != 0 || mem_addr[31:10] != 0 || mem_addr[1:0] != 0)
                stray <= stray + 1;
            if (mem_we) begin
                mem[{mem_addr[34:32], mem_addr[9:2]}] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata <= mem[{mem_addr[34:32], mem_addr[9:2]}];
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    function automatic logic [1023:0] mk_desc(vec_t v, logic [15:0] id);
        logic [1023:0] d;
        d = '0;
        d[15:0]    = id;
        d[64 +: 32] = {v.mode, v.iod, 1'b0, v.cnt, 4'b0, v.pen, 17'b0};
        d[96 +: 32] = {24'b0, v.bcnt};
        d[128 +: 32] = 32'd600;   // copy source: bank 3, word 150
        d[160 +: 32] = 32'd3;
        d[192 +: 32] = 32'd800;   // destination: bank 5, word 200
        d[224 +: 32] = 32'd5;
        for (int s = 0; s < 8; s++) begin
            d[(8 + 3*(s/2) + (s%2))*32 +: 32] = 32'(64 * s);
            d[(8 + 3*(s/2) + 2)*32 + 16*(s%2) +: 16] = 16'(s);
        end
        return d;
    endfunction

    task automatic do_init();
        @(negedge clk);
        init_req = 1'b1;
        @(negedge clk);
        init_req = 1'b0;
    endtask

    // wait for completion; returns 1 if seen
    task automatic wait_done(output logic seen);
        seen = 1'b0;
        for (int t = 0; t < 2000; t++) begin
            if (done) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic run_vec(input int i, input logic busy_poke);
        vec_t v;
        logic seen;
        logic [15:0] id;
        int nw, ns, mism;
        logic run;
        logic [31:0] exp_w, got_w;
        v  = VECS[i];
        id = 16'h1000 + 16'(i);
        nw = int'(v.bcnt) / 4;
        ns = (v.mode == 4'd1) ? 1 : int'(v.cnt);
        run = !v.err && v.mode != 4'd0 && nw != 0;
        do_init();
        desc_data  = mk_desc(v, id);
        desc_valid = 1'b1;
        @(negedge clk);
        desc_valid = 1'b0;
        desc_data  = '0;
        if (busy_poke) begin
            // conflicting no-op offered while busy must be ignored
            desc_data  = mk_desc('{4'd0, 4'd0, 1'b0, 1'b1, 8'd0, 1'b0}, 16'hBEEF);
            desc_valid = 1'b1;
            repeat (8) @(negedge clk);
            chk(!done, "R1 busy poke did not complete", done, 0);
            desc_valid = 1'b0;
            desc_data  = '0;
        end
        wait_done(seen);
        chk(seen, "R10 completion seen", seen, 1);
        chk(done_err == v.err, $sformatf("R7 err vec%0d", i), done_err, v.err);
        chk(done_irq == v.iod, $sformatf("R9 irq vec%0d", i), done_irq, v.iod);
        chk(done_id == id, $sformatf("R8 id vec%0d", i), done_id, id);
        chk(rd_cnt == (run ? nw * ns : 0), $sformatf("R6 reads vec%0d", i), rd_cnt, run ? nw * ns : 0);
        chk(wr_cnt == (run ? nw : 0), $sformatf("R6 writes vec%0d", i), wr_cnt, run ? nw : 0);
        chk(stray == 0, $sformatf("R5 addresses in range vec%0d", i), stray, 0);
        mism = 0;
        exp_w = 0;
        got_w = 0;
        for (int w = 0; w < 6; w++) begin
            logic [31:0] e;
            if (run && w < nw) begin
                e = '0;
                if (v.mode == 4'd1) e = pat(3, 150 + w);
                else for (int s = 0; s < ns; s++) e ^= pat(s, 16 * s + w);
            end else begin
                e = pat(5, 200 + w);
            end
            if (mem[5*256 + 200 + w] !== e && mism == 0) begin
                exp_w = e;
                got_w = mem[5*256 + 200 + w];
            end
            if (mem[5*256 + 200 + w] !== e) mism++;
        end
        chk(mism == 0, $sformatf("R4 R3 R2 R11 destination data vec%0d", i), got_w, exp_w);
        @(negedge clk);
        chk(!done && desc_ready, $sformatf("R10 single pulse vec%0d", i), {done, desc_ready}, 2'b01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(desc_ready == 1'b0 || desc_ready == 1'b1, "R1 ready defined in reset", desc_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(desc_ready == 1'b1, "R1 ready after reset", desc_ready, 1);
        chk(done == 1'b0, "R1 no done after reset", done, 0);
        chk(mem_req == 1'b0, "R1 no memory request after reset", mem_req, 0);
        for (int i = 0; i < NVEC; i++) begin
            run_vec(i, 1'b0);
        end
        // directed: descriptor offered while busy is ignored (R1, R8)
        run_vec(1, 1'b1);
        chk(wr_cnt == 4, "R1 poke left write count", wr_cnt, 4);
        @(negedge clk);
        chk(!done, "R1 poke never completed", done, 0);
        finish_run();
    end
endmodule